// File: doc/BRIEF.md
# Tiled View Address Generator

This unit converts one pixel coordinate into a byte offset inside a two-dimensional tiled container. Each request carries an x and a y coordinate, a pixel format code and an orientation code. The format sets how many coordinate bits are kept on each axis and how far the linear index is scaled up. The orientation can mirror either axis and can swap the axes, which gives rotated and flipped views of the same container without any copy of the data.

A request is presented with a one-cycle strobe. One clock later the unit returns the address and a valid flag. The address carries the orientation and the format in its top bits and the scaled offset below them. A coordinate outside the format's limits gives an address of zero and a cleared valid flag. The container geometry (bit counts per axis, coordinate port width, address width) is set by parameters.

Top module: `tiled_view_addr`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first strobe, `out_valid` is 0 and `out_addr` is 0.
- R2: Format codes are 0 = one byte per pixel, shifts (x 0, y 0); 1 = two bytes, (0, 1); 2 = four bytes, (1, 1); 3 = page mode, (15, 14). Kept x bits are 15 minus the x shift and kept y bits are 14 minus the y shift.
- R3: If x is larger than the all-ones value of the kept x bits, or y is larger than that of the kept y bits, then one cycle after the strobe `out_valid` is 0 and `out_addr` is 0.
- R4: Orientation bit 2 replaces x by x XOR its all-ones value; orientation bit 1 does the same for y. Both apply after the range check.
- R5: With orientation bit 0 clear the linear index is y shifted left by the kept x bits plus x; with it set the index is x shifted left by the kept y bits plus y.
- R6: The linear index is shifted left by the sum of the two format shifts, truncated to 29 bits, and its low 27 bits form `out_addr[26:0]`.
- R7: For an accepted request `out_addr[31:29]` equals the orientation code and `out_addr[28:27]` equals the format code of that request.
- R8: A result appears exactly one clock after the edge that sampled `in_valid` high; back-to-back strobes give one result per cycle. A cycle without a strobe gives `out_valid` 0 and leaves `out_addr` unchanged.
- R9: In page mode only the coordinate (0, 0) is accepted, and its offset field is 0 for every orientation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe, one cycle per request |
| x | input | 16 | Horizontal pixel coordinate |
| y | input | 16 | Vertical pixel coordinate |
| fmt | input | 2 | Pixel format code (see R2) |
| orient | input | 3 | Orientation: bit 2 mirror x, bit 1 mirror y, bit 0 swap axes |
| out_valid | output | 1 | Result valid, low for rejected coordinates |
| out_addr | output | 32 | Orientation, format and scaled offset |

## Verification
Mirroring and the axis swap act on the same request whenever several orientation bits are set at once. The bench covers all eight orientation codes on every format, both on coordinates at the axis limits and on random ones, and compares each result with a reference model written from the requirements. Rejection and acceptance also fall on adjacent cycles. Back-to-back strobes alternate in-range and just-out-of-range coordinates, and the bench checks that each result belongs to its own request and that a cycle without a strobe holds the last address.

// File: rtl/tva_pkg.sv
package tva_pkg;

   // pixel format codes
   typedef enum logic [1:0] {
      FMT_B8   = 2'd0,
      FMT_B16  = 2'd1,
      FMT_B32  = 2'd2,
      FMT_PAGE = 2'd3
   } fmt_e;

   // orientation bit positions
   localparam int ORI_SWAP  = 0;
   localparam int ORI_YFLIP = 1;
   localparam int ORI_XFLIP = 2;

   typedef struct packed {
      logic [4:0] xs;
      logic [4:0] ys;
   } shift_t;

   // per-format coordinate shifts; page mode drops every coordinate bit
   function automatic shift_t fmt_shift(input int f, input int cw, input int ch);
      shift_t s;
      case (f)
         0:       begin s.xs = 5'd0;     s.ys = 5'd0;     end
         1:       begin s.xs = 5'd0;     s.ys = 5'd1;     end
         2:       begin s.xs = 5'd1;     s.ys = 5'd1;     end
         default: begin s.xs = 5'(cw);   s.ys = 5'(ch);   end
      endcase
      return s;
   endfunction

endpackage

// File: rtl/tva_geom.sv
module tva_geom #(
   parameter int CW      = 15,
   parameter int CH      = 14,
   parameter int COORD_W = 16
) (
   input  logic [1:0]         fmt,
   output logic [4:0]         xbits,
   output logic [4:0]         ybits,
   output logic [COORD_W-1:0] xmask,
   output logic [COORD_W-1:0] ymask,
   output logic [5:0]         scale
);
   import tva_pkg::*;

   localparam int NFMT = 4;

   logic [4:0]         xb_t [NFMT];
   logic [4:0]         yb_t [NFMT];
   logic [COORD_W-1:0] xm_t [NFMT];
   logic [COORD_W-1:0] ym_t [NFMT];
   logic [5:0]         sc_t [NFMT];

   // one constant geometry row per format
   for (genvar f = 0; f < NFMT; f++) begin : g_fmt
      localparam shift_t S  = fmt_shift(f, CW, CH);
      localparam int     XB = CW - int'(S.xs);
      localparam int     YB = CH - int'(S.ys);
      localparam logic [COORD_W-1:0] XM = COORD_W'((64'd1 << XB) - 64'd1);
      localparam logic [COORD_W-1:0] YM = COORD_W'((64'd1 << YB) - 64'd1);
      assign xb_t[f] = 5'(XB);
      assign yb_t[f] = 5'(YB);
      assign xm_t[f] = XM;
      assign ym_t[f] = YM;
      assign sc_t[f] = 6'(int'(S.xs) + int'(S.ys));
   end

   assign xbits = xb_t[fmt];
   assign ybits = yb_t[fmt];
   assign xmask = xm_t[fmt];
   assign ymask = ym_t[fmt];
   assign scale = sc_t[fmt];

endmodule

// File: rtl/tva_fold.sv
module tva_fold #(
   parameter int COORD_W = 16,
   parameter int OFF_W   = 29
) (
   input  logic [COORD_W-1:0] x,
   input  logic [COORD_W-1:0] y,
   input  logic [2:0]         orient,
   input  logic [4:0]         xbits,
   input  logic [4:0]         ybits,
   input  logic [COORD_W-1:0] xmask,
   input  logic [COORD_W-1:0] ymask,
   input  logic [5:0]         scale,
   output logic               in_range,
   output logic [OFF_W-1:0]   offset
);
   import tva_pkg::*;

   localparam int PAD_W = OFF_W - COORD_W;

   logic [COORD_W-1:0] xm, ym;
   logic [OFF_W-1:0]   xe, ye, idx;

   if (PAD_W < 1) begin : g_bad_pad
      $error("offset field must be wider than a coordinate");
   end

   assign in_range = (x <= xmask) && (y <= ymask);

   // mirror by inverting the kept bits of each axis
   assign xm = orient[ORI_XFLIP] ? (x ^ xmask) : x;
   assign ym = orient[ORI_YFLIP] ? (y ^ ymask) : y;

   assign xe = {{PAD_W{1'b0}}, xm};
   assign ye = {{PAD_W{1'b0}}, ym};

   // coordinates are disjoint bit ranges, so the sum never carries
   assign idx = orient[ORI_SWAP] ? ((xe << ybits) + ye)
                                 : ((ye << xbits) + xe);

   assign offset = idx << scale;

endmodule

// File: rtl/tiled_view_addr.sv
module tiled_view_addr #(
   parameter int CW      = 15,
   parameter int CH      = 14,
   parameter int COORD_W = 16,
   parameter int ADDR_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [15:0]       x,
   input  logic [15:0]       y,
   input  logic [1:0]        fmt,
   input  logic [2:0]        orient,
   output logic              out_valid,
   output logic [31:0]       out_addr
);
   localparam int OFF_W = CW + CH;
   localparam int ORI_W = 3;
   localparam int FMT_W = 2;
   localparam int LOW_W = ADDR_W - ORI_W - FMT_W;

   if (COORD_W != 16 || ADDR_W != 32) begin : g_bad_port
      $error("port widths are fixed at 16-bit coordinates and 32-bit address");
   end
   if (COORD_W <= CW || COORD_W <= CH) begin : g_bad_coord
      $error("coordinate port must be wider than either container axis");
   end
   if (LOW_W < 1) begin : g_bad_low
      $error("address too narrow for orientation and format fields");
   end

   logic [4:0]         xbits, ybits;
   logic [COORD_W-1:0] xmask, ymask;
   logic [5:0]         scale;
   logic               in_range;
   logic [OFF_W-1:0]   offset;
   logic [LOW_W-1:0]   low_off;
   logic [ADDR_W-1:0]  addr_next;

   tva_geom #(.CW(CW), .CH(CH), .COORD_W(COORD_W)) geom_i (
      .fmt   (fmt),
      .xbits (xbits),
      .ybits (ybits),
      .xmask (xmask),
      .ymask (ymask),
      .scale (scale)
   );

   tva_fold #(.COORD_W(COORD_W), .OFF_W(OFF_W)) fold_i (
      .x        (x),
      .y        (y),
      .orient   (orient),
      .xbits    (xbits),
      .ybits    (ybits),
      .xmask    (xmask),
      .ymask    (ymask),
      .scale    (scale),
      .in_range (in_range),
      .offset   (offset)
   );

   // offset wider than the low field is cut; narrower is zero-extended
   if (LOW_W < OFF_W) begin : g_trunc
      assign low_off = LOW_W'(offset);
   end else begin : g_extend
      assign low_off = {{(LOW_W - OFF_W){1'b0}}, offset};
   end

   assign addr_next = in_range ? {orient, fmt, low_off} : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
      end else begin
         out_valid <= in_valid && in_range;
         if (in_valid) out_addr <= addr_next;
      end
   end

   // R8
   valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   // R8
   hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_addr) && !out_valid);

   // R3
   reject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_range |=> !out_valid && out_addr == '0);

   // R7
   orient_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_range |=> out_valid && out_addr[31:29] == $past(orient));

   // R7
   fmt_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_range |=> out_addr[28:27] == $past(fmt));

   // R9
   page_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && fmt == 2'd3 |=> out_addr[26:0] == '0);

endmodule

// File: tb/tiled_view_addr_tb.sv
`timescale 1ns/1ps
module tiled_view_addr_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [15:0] x, y;
   logic [1:0]  fmt;
   logic [2:0]  orient;
   logic        out_valid;
   logic [31:0] out_addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic [31:0] last_addr;

   always #4 clk = ~clk;

   tiled_view_addr dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .x         (x),
      .y         (y),
      .fmt       (fmt),
      .orient    (orient),
      .out_valid (out_valid),
      .out_addr  (out_addr)
   );

   // reference model built from R2..R7, R9: returns {valid, address}
   function automatic logic [32:0] model(input logic [15:0] xi, input logic [15:0] yi,
                                          input logic [1:0] f, input logic [2:0] o);
      longint xs, ys, xb, yb, xm, ym, xv, yv, idx, off;
      case (f)
         2'd0:    begin xs = 0;  ys = 0;  end
         2'd1:    begin xs = 0;  ys = 1;  end
         2'd2:    begin xs = 1;  ys = 1;  end
         default: begin xs = 15; ys = 14; end
      endcase
      xb = 15 - xs;
      yb = 14 - ys;
      xm = (64'd1 << xb) - 1;
      ym = (64'd1 << yb) - 1;
      xv = longint'(xi);
      yv = longint'(yi);
      if (xv > xm || yv > ym) return 33'd0;
      if (o[2]) xv = xv ^ xm;
      if (o[1]) yv = yv ^ ym;
      idx = o[0] ? ((xv << yb) + yv) : ((yv << xb) + xv);
      off = (idx << (xs + ys)) & 64'h1FFF_FFFF;
      off = off & 64'h07FF_FFFF;
      return {1'b1, o, f, off[26:0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // strobe one request and check its result on the next falling edge
   task automatic apply(input logic [15:0] xi, input logic [15:0] yi,
                        input logic [1:0] f, input logic [2:0] o, input string req);
      logic [32:0] e;
      @(negedge clk);
      x = xi; y = yi; fmt = f; orient = o; in_valid = 1'b1;
      e = model(xi, yi, f, o);
      @(negedge clk);
      check({req, " valid"}, {31'd0, out_valid}, {31'd0, e[32]});
      check({req, " addr"}, out_addr, e[31:0]);
      last_addr = e[31:0];
   endtask

   function automatic logic [15:0] pick(input int lim);
      int r;
      r = int'($urandom() % 8);
      case (r)
         0: return 16'(lim);
         1: return 16'(lim + 1);
         2: return 16'd0;
         3: return 16'($urandom());
         default: return 16'($urandom() % (lim + 1));
      endcase
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = int'($urandom(32'd7781));
      rst_n = 1'b0; in_valid = 1'b1; x = 16'd5; y = 16'd5; fmt = 2'd0; orient = 3'd0;
      repeat (3) @(negedge clk);
      // R1: reset holds outputs low even with a strobe present
      check("R1 reset valid", {31'd0, out_valid}, 32'd0);
      check("R1 reset addr", out_addr, 32'd0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset addr", out_addr, 32'd0);

      // R2, R5, R6: each format at its largest in-range point
      apply(16'd32767, 16'd16383, 2'd0, 3'b000, "R2 R6 fmt0 max");
      apply(16'd32767, 16'd8191,  2'd1, 3'b000, "R2 R6 fmt1 max");
      apply(16'd16383, 16'd8191,  2'd2, 3'b000, "R2 R6 fmt2 max");
      apply(16'd3,     16'd2,     2'd2, 3'b000, "R6 fmt2 scale");
      // R3: just past each limit, adjacent to accepted requests
      apply(16'd32768, 16'd0,     2'd0, 3'b000, "R3 x over");
      apply(16'd10,    16'd16384, 2'd0, 3'b000, "R3 y over");
      apply(16'd10,    16'd8192,  2'd1, 3'b101, "R3 fmt1 y over");
      apply(16'd16384, 16'd1,     2'd2, 3'b000, "R3 fmt2 x over");
      apply(16'd1,     16'd1,     2'd0, 3'b000, "R3 R8 accept after reject");
      // R4, R5: mirrors and swap, alone and together
      apply(16'd1,     16'd2,     2'd0, 3'b100, "R4 xflip");
      apply(16'd1,     16'd2,     2'd0, 3'b010, "R4 yflip");
      apply(16'd1,     16'd2,     2'd0, 3'b001, "R5 swap");
      apply(16'd1,     16'd2,     2'd1, 3'b111, "R4 R5 all");
      apply(16'd0,     16'd0,     2'd2, 3'b110, "R4 both flips at origin");
      // R9: page mode
      apply(16'd0,     16'd0,     2'd3, 3'b111, "R9 page origin");
      apply(16'd1,     16'd0,     2'd3, 3'b000, "R9 page x reject");
      apply(16'd0,     16'd1,     2'd3, 3'b011, "R9 page y reject");
      apply(16'd0,     16'd0,     2'd3, 3'b000, "R9 page origin plain");

      // R8: no strobe keeps the address and clears valid
      @(negedge clk);
      in_valid = 1'b0; x = 16'hFFFF; fmt = 2'd1; orient = 3'd5;
      @(negedge clk);
      check("R8 hold valid", {31'd0, out_valid}, 32'd0);
      check("R8 hold addr", out_addr, last_addr);
      @(negedge clk);
      check("R8 hold addr second", out_addr, last_addr);

      // R2..R7: random requests near and inside the limits, all orientations
      for (int i = 0; i < 400; i++) begin
         logic [1:0] f;
         int xl, yl;
         f = 2'($urandom());
         case (f)
            2'd0:    begin xl = 32767; yl = 16383; end
            2'd1:    begin xl = 32767; yl = 8191;  end
            2'd2:    begin xl = 16383; yl = 8191;  end
            default: begin xl = 0;     yl = 0;     end
         endcase
         apply(pick(xl), pick(yl), f, 3'($urandom()), "R2-rand R4 R5 R6 R7");
         if (($urandom() % 16) == 0) begin
            in_valid = 1'b0;
            @(negedge clk);
            check("R8 random gap", out_addr, last_addr);
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule